// File: doc/BRIEF.md
# Keyed configuration front end with device-banked registers

This block sits in front of the configuration space of a multi-function I/O controller. Software reaches it through a byte-wide write bus with two addresses: an index port (address 0) and a data port (address 1, one above the index port). There is also a combinational read path over the same two addresses. Configuration space is sealed after reset. A two-byte key written to the index port unseals it, and a single closing byte seals it again. While it is unsealed, an index write names a register and a data write stores into the named register.

The unlock sequencing is an enumerated state machine with three states. GATE_LOCKED is the reset state. GATE_HALF is entered from GATE_LOCKED by an index write of 0x87. GATE_OPEN is entered from GATE_HALF by a second index write of 0x87. From GATE_HALF, any other write (an index write of some other value, or any data write) takes the abort transition back to GATE_LOCKED. In GATE_OPEN, an index write of 0xAA takes the close transition back to GATE_LOCKED. Every other index write in GATE_OPEN stays in GATE_OPEN and loads the index pointer.

The registers come in two kinds. Registers 0x00 to 0x2F are global and are shared by all devices. Register 0x07 is the device-select register. Registers 0x30 to 0xFF are banked: each logical device has its own copy, and the value in register 0x07 picks which copy an access reaches. Bit 0 of banked register 0x30 activates that device. A 16-bit base address is held as a high byte at an even register (for example 0x60) and a low byte at the next register (0x61). Bit 0 of registers 0xE1 to 0xE7 in device 7 sets the direction of pins 0 to 6. Bit 0 of registers 0xE8 to 0xEB in device 8 sets the direction of pins 7 to 10.

Top module: `sio_cfg_front`

## Requirements
- R1: After reset the gate is locked (cfg_open=0), both read ports return 0xFF, and dev_active and pin_dir are all zero.
- R2: Two index-port writes of 0x87 in a row open the gate; cfg_open is 1 from the cycle after the second write.
- R3: After a single 0x87, an index write of any other value or any data write returns the sequence to locked, and a later lone 0x87 does not open the gate.
- R4: While open, an index write of 0xAA closes the gate; cfg_open is 0 from the next cycle.
- R5: While the gate is closed, data writes are ignored (no register, dev_active or pin_dir changes), and reads of either port return 0xFF.
- R6: While open, an index write loads the pointer, which reads back on the index port (rd_port=0). A data write stores into the named register, and the stored value reads back on the data port (rd_port=1) in the next cycle. The two bytes of a base-address pair (0x60 high, 0x61 low) are held independently.
- R7: Register 0x07 selects the logical device. Registers 0x30 to 0xFF are kept per device, so a value written in one device's bank is not seen while another device is selected.
- R8: Registers 0x00 to 0x2F read and write the same storage whatever device is selected.
- R9: dev_active[d] equals bit 0 of register 0x30 in device d's bank.
- R10: pin_dir[i] equals bit 0 of register 0xE1+i in device 7 for i=0..6, and bit 0 of register 0xE8+(i-7) in device 8 for i=7..10.
- R11: When the selected device number is NUM_DEV or higher, data writes to banked registers are ignored and data-port reads of banked registers return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_port | input | 1 | Write target: 0 = index port, 1 = data port |
| wr_data | input | 8 | Write byte |
| rd_port | input | 1 | Read source: 0 = index pointer, 1 = named register |
| rd_data | output | 8 | Read byte (combinational) |
| cfg_open | output | 1 | Gate is in GATE_OPEN |
| dev_active | output | NUM_DEV (9) | Per-device activate bit |
| pin_dir | output | 11 | Per-pin direction bits from devices 7 and 8 |

## Verification
Every write lands on a clock edge and all its effects are due one cycle later. That covers the gate state on cfg_open, the index pointer, the stored register, dev_active and pin_dir. The reads are combinational from that registered state, so a written value is readable in the same cycle in which cfg_open changes. The bench presents each write at a falling edge and lets one rising edge pass. At the next falling edge it compares both read ports, cfg_open, dev_active and pin_dir against a reference model that it updates from the requirements alone. Randomly mixed index writes, data writes and key bytes with a fixed seed follow directed runs of the key sequences, the aborts, bank isolation and out-of-range selects.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_HALF   = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_t;

    localparam logic [7:0] KEY_OPEN   = 8'h87;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] REG_DEVSEL = 8'h07;
    localparam logic [7:0] REG_ACT    = 8'h30;
    localparam int         BANK_BASE  = 48;   // first banked register (0x30)
    localparam int         REG_SPACE  = 256;
endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wr_data,
    output logic       open_o,
    output logic       idx_cap,
    output logic       reg_wr
);
    gate_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATE_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_LOCKED: if (idx_wr && wr_data == KEY_OPEN) state_nx = GATE_HALF;
            GATE_HALF: begin
                if (idx_wr && wr_data == KEY_OPEN) state_nx = GATE_OPEN;
                else if (idx_wr || data_wr)        state_nx = GATE_LOCKED;
            end
            GATE_OPEN:   if (idx_wr && wr_data == KEY_CLOSE) state_nx = GATE_LOCKED;
            default:     state_nx = GATE_LOCKED;
        endcase
    end

    always_comb begin
        open_o  = (state == GATE_OPEN);
        idx_cap = open_o && idx_wr && (wr_data != KEY_CLOSE);
        reg_wr  = open_o && data_wr;
    end

    // R2
    open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(idx_wr && wr_data == KEY_OPEN));
    // R4
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && idx_wr && wr_data == KEY_CLOSE) |=> !open_o);
    // R3
    half_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_HALF && (data_wr || (idx_wr && wr_data != KEY_OPEN)))
        |=> state == GATE_LOCKED);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int NUM_DEV      = 9,
    parameter int GPIO_A_DEV   = 7,
    parameter int GPIO_A_FIRST = 225,
    parameter int GPIO_A_PINS  = 7,
    parameter int GPIO_B_DEV   = 8,
    parameter int GPIO_B_FIRST = 232,
    parameter int GPIO_B_PINS  = 4,
    localparam int PINS        = GPIO_A_PINS + GPIO_B_PINS
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_i,
    input  logic               idx_cap,
    input  logic               reg_wr,
    input  logic [7:0]         wr_data,
    input  logic               rd_port,
    output logic [7:0]         rd_data,
    output logic [NUM_DEV-1:0] dev_active,
    output logic [PINS-1:0]    pin_dir
);
    localparam int BANK_N = REG_SPACE - BANK_BASE;
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int OFF_W  = $clog2(BANK_N);
    localparam int GIDX_W = $clog2(BANK_BASE);

    logic [7:0] glob [BANK_BASE];
    logic [7:0] bank [NUM_DEV][BANK_N];
    logic [7:0] idx;

    logic [7:0]        sel;
    logic [SEL_W-1:0]  sel_i;
    logic              sel_ok;
    logic              is_glob;
    logic [7:0]        off;
    logic [OFF_W-1:0]  off_i;
    logic [GIDX_W-1:0] gidx;

    assign sel     = glob[REG_DEVSEL[GIDX_W-1:0]];
    assign sel_i   = sel[SEL_W-1:0];
    assign sel_ok  = (sel < 8'(NUM_DEV));
    assign is_glob = (idx < 8'(BANK_BASE));
    assign off     = idx - 8'(BANK_BASE);
    assign off_i   = off[OFF_W-1:0];
    assign gidx    = idx[GIDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            for (int g = 0; g < BANK_BASE; g++) glob[g] <= '0;
            for (int d = 0; d < NUM_DEV; d++)
                for (int r = 0; r < BANK_N; r++) bank[d][r] <= '0;
        end else begin
            if (idx_cap) idx <= wr_data;
            if (reg_wr) begin
                if (is_glob)     glob[gidx] <= wr_data;
                else if (sel_ok) bank[sel_i][off_i] <= wr_data;
            end
        end
    end

    always_comb begin
        if (!open_i)      rd_data = 8'hFF;
        else if (!rd_port) rd_data = idx;
        else if (is_glob) rd_data = glob[gidx];
        else if (sel_ok)  rd_data = bank[sel_i][off_i];
        else              rd_data = 8'hFF;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_act
        assign dev_active[d] = bank[d][int'(REG_ACT) - BANK_BASE][0];
    end
    for (genvar p = 0; p < GPIO_A_PINS; p++) begin : g_pa
        assign pin_dir[p] = bank[GPIO_A_DEV][GPIO_A_FIRST - BANK_BASE + p][0];
    end
    for (genvar p = 0; p < GPIO_B_PINS; p++) begin : g_pb
        assign pin_dir[GPIO_A_PINS + p] = bank[GPIO_B_DEV][GPIO_B_FIRST - BANK_BASE + p][0];
    end

    // R5
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> ($stable(dev_active) && $stable(pin_dir)));
    // R9
    act_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_ok && idx == REG_ACT) |=> dev_active[$past(sel_i)] == $past(wr_data[0]));
    // R10
    gpio_a_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == 8'(GPIO_A_DEV) && idx == 8'(GPIO_A_FIRST)) |=> pin_dir[0] == $past(wr_data[0]));
    // R11
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !sel_ok && !is_glob) |=> ($stable(dev_active) && $stable(pin_dir)));
endmodule

// File: rtl/sio_cfg_front.sv
module sio_cfg_front
    import sio_cfg_pkg::*;
#(
    parameter int NUM_DEV      = 9,
    parameter int GPIO_A_DEV   = 7,
    parameter int GPIO_A_FIRST = 225,
    parameter int GPIO_A_PINS  = 7,
    parameter int GPIO_B_DEV   = 8,
    parameter int GPIO_B_FIRST = 232,
    parameter int GPIO_B_PINS  = 4
)(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_port,
    input  logic [7:0]                          wr_data,
    input  logic                                rd_port,
    output logic [7:0]                          rd_data,
    output logic                                cfg_open,
    output logic [NUM_DEV-1:0]                  dev_active,
    output logic [GPIO_A_PINS+GPIO_B_PINS-1:0]  pin_dir
);
    logic idx_wr, data_wr, idx_cap, reg_wr;

    assign idx_wr  = wr_en && !wr_port;
    assign data_wr = wr_en && wr_port;

    sio_cfg_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .wr_data (wr_data),
        .open_o  (cfg_open),
        .idx_cap (idx_cap),
        .reg_wr  (reg_wr)
    );

    sio_cfg_regs #(
        .NUM_DEV      (NUM_DEV),
        .GPIO_A_DEV   (GPIO_A_DEV),
        .GPIO_A_FIRST (GPIO_A_FIRST),
        .GPIO_A_PINS  (GPIO_A_PINS),
        .GPIO_B_DEV   (GPIO_B_DEV),
        .GPIO_B_FIRST (GPIO_B_FIRST),
        .GPIO_B_PINS  (GPIO_B_PINS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (cfg_open),
        .idx_cap    (idx_cap),
        .reg_wr     (reg_wr),
        .wr_data    (wr_data),
        .rd_port    (rd_port),
        .rd_data    (rd_data),
        .dev_active (dev_active),
        .pin_dir    (pin_dir)
    );
endmodule

// File: tb/sio_cfg_front_bench.sv
module sio_cfg_front_bench;
    localparam int ND = 9;
    localparam int NP = 11;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0, wr_port = 0, rd_port = 0;
    logic [7:0]    wr_data = 0;
    logic [7:0]    rd_data;
    logic          cfg_open;
    logic [ND-1:0] dev_active;
    logic [NP-1:0] pin_dir;

    always #5 clk = ~clk;

    sio_cfg_front u_sio_cfg_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
        .wr_data(wr_data), .rd_port(rd_port), .rd_data(rd_data),
        .cfg_open(cfg_open), .dev_active(dev_active), .pin_dir(pin_dir)
    );

    int total = 0, bad = 0;

    // reference model
    int         m_st;   // 0 locked, 1 half, 2 open
    logic [7:0] m_idx;
    logic [7:0] m_glob [48];
    logic [7:0] m_bank [ND][208];

    task automatic model_reset();
        m_st = 0; m_idx = 0;
        for (int g = 0; g < 48; g++) m_glob[g] = 0;
        for (int d = 0; d < ND; d++) for (int r = 0; r < 208; r++) m_bank[d][r] = 0;
    endtask

    task automatic model_write(input logic a, input logic [7:0] d);
        if (!a) begin
            if (m_st == 0)      begin if (d == 8'h87) m_st = 1; end
            else if (m_st == 1) m_st = (d == 8'h87) ? 2 : 0;
            else if (d == 8'hAA) m_st = 0;
            else m_idx = d;
        end else begin
            if (m_st == 1) m_st = 0;
            else if (m_st == 2) begin
                if (m_idx < 8'h30) m_glob[m_idx] = d;
                else if (m_glob[7] < ND) m_bank[m_glob[7]][m_idx - 8'h30] = d;
            end
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic p);
        if (m_st != 2) return 8'hFF;
        if (!p) return m_idx;
        if (m_idx < 8'h30) return m_glob[m_idx];
        if (m_glob[7] < ND) return m_bank[m_glob[7]][m_idx - 8'h30];
        return 8'hFF;
    endfunction

    function automatic logic [ND-1:0] exp_act();
        logic [ND-1:0] v;
        for (int d = 0; d < ND; d++) v[d] = m_bank[d][0][0];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_pins();
        logic [NP-1:0] v;
        for (int i = 0; i < 7; i++) v[i] = m_bank[7][8'hE1 - 8'h30 + i][0];
        for (int i = 0; i < 4; i++) v[7+i] = m_bank[8][8'hE8 - 8'h30 + i][0];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a falling edge
    task automatic check_all(input string t_open, input string t_rd, input string t_act, input string t_pin);
        chk(t_open, 32'(cfg_open), 32'(m_st == 2));
        rd_port = 0; #1;
        chk({t_rd, " index read"}, 32'(rd_data), 32'(exp_rd(0)));
        rd_port = 1; #1;
        chk({t_rd, " data read"}, 32'(rd_data), 32'(exp_rd(1)));
        chk(t_act, 32'(dev_active), 32'(exp_act()));
        chk(t_pin, 32'(pin_dir), 32'(exp_pins()));
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_port = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wr_chk(input logic a, input logic [7:0] d, input string tag);
        wr(a, d);
        check_all(tag, tag, tag, tag);
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset open", "R1 reset", "R1 reset act", "R1 reset pins");

        // R5: closed, data writes ignored
        wr_chk(1, 8'h01, "R5 closed data write");
        wr_chk(1, 8'hFF, "R5 closed data write");

        // R3: abort by other index byte, then by data write
        wr_chk(0, 8'h87, "R3 first key");
        wr_chk(0, 8'h55, "R3 abort index");
        wr_chk(0, 8'h87, "R3 lone key");
        wr_chk(1, 8'h87, "R3 abort data");
        wr_chk(0, 8'h87, "R3 lone key again");
        wr_chk(0, 8'hAA, "R3 abort close byte");

        // R2: open
        wr_chk(0, 8'h87, "R2 key1");
        wr_chk(0, 8'h87, "R2 key2");

        // R6: pointer and base-address pair
        wr_chk(0, 8'h07, "R6 index");
        wr_chk(1, 8'h05, "R7 select dev5");
        wr_chk(0, 8'h60, "R6 index hi");
        wr_chk(1, 8'h03, "R6 base hi");
        wr_chk(0, 8'h61, "R6 index lo");
        wr_chk(1, 8'h38, "R6 base lo");
        wr_chk(0, 8'h60, "R6 hi readback");

        // R9: activate dev5
        wr_chk(0, 8'h30, "R9 index act");
        wr_chk(1, 8'h01, "R9 activate dev5");

        // R7: other bank does not see dev5 values
        wr_chk(0, 8'h07, "R7 index sel");
        wr_chk(1, 8'h02, "R7 select dev2");
        wr_chk(0, 8'h60, "R7 dev2 base empty");
        wr_chk(0, 8'h30, "R7 dev2 act empty");

        // R8: global reg shared
        wr_chk(0, 8'h22, "R8 index global");
        wr_chk(1, 8'hFE, "R8 write global");
        wr_chk(0, 8'h07, "R8 sel");
        wr_chk(1, 8'h06, "R8 select dev6");
        wr_chk(0, 8'h22, "R8 global under dev6");

        // R10: GPIO direction pins
        wr_chk(0, 8'h07, "R10 sel");
        wr_chk(1, 8'h07, "R10 select dev7");
        wr_chk(0, 8'hE1, "R10 idx E1");
        wr_chk(1, 8'h01, "R10 pin0");
        wr_chk(0, 8'hE7, "R10 idx E7");
        wr_chk(1, 8'h03, "R10 pin6");
        wr_chk(0, 8'hE8, "R10 idx E8 dev7");
        wr_chk(1, 8'h01, "R10 E8 in dev7 no pin");
        wr_chk(0, 8'h07, "R10 sel");
        wr_chk(1, 8'h08, "R10 select dev8");
        wr_chk(0, 8'hEB, "R10 idx EB");
        wr_chk(1, 8'h01, "R10 pin10");

        // R11: out-of-range device
        wr_chk(0, 8'h07, "R11 sel");
        wr_chk(1, 8'h0C, "R11 select dev12");
        wr_chk(0, 8'h30, "R11 idx act");
        wr_chk(1, 8'h01, "R11 ignored write");
        wr_chk(0, 8'hE1, "R11 read ff");

        // R4: close, then R5 again
        wr_chk(0, 8'hAA, "R4 close");
        wr_chk(1, 8'h00, "R5 closed write after close");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [7:0] v;
            r = int'($urandom % 100);
            if (r < 40) begin
                case ($urandom % 6)
                    0: v = 8'h07;
                    1: v = 8'h30;
                    2: v = 8'hE1 + 8'($urandom % 11);
                    3: v = 8'h60 + 8'($urandom % 4);
                    4: v = 8'($urandom % 48);
                    default: v = 8'($urandom);
                endcase
                wr(0, v);
            end else if (r < 92) begin
                v = (m_idx == 8'h07) ? 8'($urandom % 10) : 8'($urandom);
                wr(1, v);
            end else begin
                v = ($urandom % 4 == 0) ? 8'hAA : 8'h87;
                wr(0, v);
            end
            check_all("R2 random open", "R6 random", "R9 random act", "R10 random pins");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule